// File: doc/BRIEF.md
# Converter Module Configuration Controller

This block holds the 16-bit configuration word of an analog-to-digital converter module and turns its fields into control signals. A halt field gates the converter clock enable, powers the analog front end down and aborts the conversion sequence at once. A hold-enable field lets an external freeze request stop the sequencer, but only after the conversion in flight has finished. A mode field selects legacy or enhanced operation, and it can be changed only while a separate unlock field is set.

Every access on the simple register bus is checked against a privilege policy. Either a small set of control registers, or the whole module map, can be reserved for supervisor accesses. A user access to a reserved location is blocked: a blocked write has no effect, a blocked read returns zero, and an error pulse is raised. When the halt field is cleared, a ready flag stays low for a programmable analog recovery interval before conversions may start again.

Field positions use MSB-first numbering, so field number n sits at data bit 15-n. Halt is data[15], hold-enable is data[14], unlock is data[9], mode is data[8] and whole-map privilege is data[7]. All other bits are reserved.

Top module: `adc_cfg_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x0080 (whole-map privilege set, all else 0), with mode_enh=0, conv_clk_en=1, analog_pd=0, seq_abort=0, seq_hold=0, conv_ready=1 and bus_err=0.
- R2: While the halt field (data[15]) is 1, conv_clk_en is 0, and analog_pd and seq_abort are 1. All three follow the field from the clock edge of the write that sets it, with no wait for a conversion.
- R3: conv_ready is 0 while halted. After the write edge that clears halt, conv_ready rises exactly REC_CYC clock edges later. Setting halt again during the countdown restarts the full interval on the next clear.
- R4: A permitted write to the configuration address (0) loads halt, hold-enable (data[14]), unlock (data[9]) and whole-map privilege (data[7]) at that clock edge.
- R5: The mode field (data[8], output mode_enh; 0 legacy, 1 enhanced) takes the written value only if unlock was 1 before the write. A write that sets unlock and mode together leaves mode unchanged.
- R6: With hold-enable 1, seq_hold rises on the first clock edge that samples frz_req=1 and conv_busy=0. It stays high while frz_req stays 1, and it falls on the edge that samples frz_req=0.
- R7: With hold-enable 0, frz_req is ignored and seq_hold stays 0.
- R8: With whole-map privilege 0, only addresses 0 (configuration), 1 (test) and 2 (interrupt) are supervisor-only. With it set to 1, every address is supervisor-only. bus_user=1 marks a user access.
- R9: An access is blocked when it comes from user mode to a supervisor-only address. bus_permit is 1 during an unblocked access and 0 otherwise. bus_err is a one-cycle pulse on the edge after each blocked access.
- R10: A blocked write leaves the configuration word unchanged, and a blocked read returns 0.
- R11: bus_rdata carries the configuration word in the cycle after a permitted read of address 0, with reserved bits 0. It is 0 after a read of any other address, and writes to reserved bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address within the module |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_user | input | 1 | 1 = user-mode access, 0 = supervisor |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read |
| bus_permit | output | 1 | Access allowed to proceed (combinational) |
| bus_err | output | 1 | Access-violation pulse |
| frz_req | input | 1 | External freeze request |
| conv_busy | input | 1 | A conversion is in progress |
| conv_clk_en | output | 1 | Converter clock enable |
| analog_pd | output | 1 | Analog power-down |
| seq_abort | output | 1 | Abort the conversion sequence |
| seq_hold | output | 1 | Freeze acknowledge / sequencer hold |
| mode_enh | output | 1 | 1 = enhanced mode, 0 = legacy |
| conv_ready | output | 1 | Analog circuits recovered, conversions allowed |

## Verification
A corrupted field in the configuration word shows within one cycle: it appears at mode_enh, conv_clk_en, analog_pd or seq_abort, and in the next readback of address 0. A wrong unlock value is exposed by the next mode write, which then takes or misses its effect. A recovery counter that loads or decrements wrongly shifts the rising edge of conv_ready away from the expected edge count. A wrong privilege decision appears in the same cycle at bus_permit and one edge later at bus_err.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;
  localparam int CW     = 16;
  localparam int B_HALT = 15;
  localparam int B_HOLD = 14;
  localparam int B_UNLK = 9;
  localparam int B_ENH  = 8;
  localparam int B_PRIV = 7;

  typedef struct packed {
    logic halt;
    logic hold_en;
    logic unlock;
    logic enh;
    logic priv_all;
  } cfg_t;

  localparam cfg_t CFG_RST = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  function automatic logic [CW-1:0] pack_cfg(input cfg_t c);
    logic [CW-1:0] w;
    w = '0;
    w[B_HALT] = c.halt;
    w[B_HOLD] = c.hold_en;
    w[B_UNLK] = c.unlock;
    w[B_ENH]  = c.enh;
    w[B_PRIV] = c.priv_all;
    return w;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cfg_priv_gate.sv
module cfg_priv_gate #(
  parameter int ADDR_W = 8,
  parameter int CFG_A  = 0,
  parameter int TST_A  = 1,
  parameter int IRQ_A  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              user,
  input  logic              priv_all,
  output logic              cfg_hit,
  output logic              permit,
  output logic              blocked
);
  localparam int NSMALL = 3;
  localparam logic [NSMALL*ADDR_W-1:0] SMALL =
    {ADDR_W'(IRQ_A), ADDR_W'(TST_A), ADDR_W'(CFG_A)};

  logic [NSMALL-1:0] small_hit;
  logic              prot;
  logic              access;

  genvar g;
  generate
    for (g = 0; g < NSMALL; g++) begin : g_small
      assign small_hit[g] = (addr == SMALL[g*ADDR_W +: ADDR_W]);
    end
  endgenerate

  always_comb begin
    access  = wr | rd;
    cfg_hit = small_hit[0];
    prot    = priv_all | (|small_hit);
    blocked = access & user & prot;
    permit  = access & ~blocked;
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import adc_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          wr_ok,
  input  logic [CW-1:0] wdata,
  output cfg_t          cfg_q
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d          = cfg_q;
    cfg_d.halt     = wdata[B_HALT];
    cfg_d.hold_en  = wdata[B_HOLD];
    cfg_d.unlock   = wdata[B_UNLK];
    cfg_d.priv_all = wdata[B_PRIV];
    cfg_d.enh      = cfg_q.unlock ? wdata[B_ENH] : cfg_q.enh;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    cfg_q <= CFG_RST;
    else if (wr_ok) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cfg_recovery.sv
module cfg_recovery #(
  parameter int REC_CYC = 64
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic halt,
  output logic ready
);
  localparam int CNT_W = $clog2(REC_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = halt | (cnt_q != '0);
    cnt_d  = halt ? CNT_W'(REC_CYC) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = ~halt & (cnt_q == '0);
endmodule

// File: rtl/cfg_freeze.sv
module cfg_freeze (
  input  logic clk,
  input  logic rst_sn,
  input  logic hold_en,
  input  logic frz_req,
  input  logic busy,
  output logic hold_q
);
  logic hold_d;

  always_comb begin
    if (hold_q) hold_d = hold_en & frz_req;
    else        hold_d = hold_en & frz_req & ~busy;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) hold_q <= 1'b0;
    else         hold_q <= hold_d;
  end
endmodule

// File: rtl/adc_cfg_ctrl.sv
module adc_cfg_ctrl
  import adc_cfg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REC_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_user,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  output logic              bus_permit,
  output logic              bus_err,
  input  logic              frz_req,
  input  logic              conv_busy,
  output logic              conv_clk_en,
  output logic              analog_pd,
  output logic              seq_abort,
  output logic              seq_hold,
  output logic              mode_enh,
  output logic              conv_ready
);
  logic          rst_s;
  cfg_t          cfg;
  logic [CW-1:0] cfg_word;
  logic          cfg_hit, permit, blocked, wr_ok;
  logic [CW-1:0] rdata_d;

  cfg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_s));

  cfg_priv_gate #(.ADDR_W(ADDR_W)) u_gate (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .user(bus_user),
    .priv_all(cfg.priv_all), .cfg_hit(cfg_hit), .permit(permit),
    .blocked(blocked)
  );

  assign wr_ok = bus_wr & permit & cfg_hit;

  cfg_store u_store (
    .clk(clk), .rst_sn(rst_s), .wr_ok(wr_ok), .wdata(bus_wdata), .cfg_q(cfg)
  );

  cfg_recovery #(.REC_CYC(REC_CYC)) u_rec (
    .clk(clk), .rst_sn(rst_s), .halt(cfg.halt), .ready(conv_ready)
  );

  cfg_freeze u_frz (
    .clk(clk), .rst_sn(rst_s), .hold_en(cfg.hold_en), .frz_req(frz_req),
    .busy(conv_busy), .hold_q(seq_hold)
  );

  assign cfg_word = pack_cfg(cfg);

  always_comb begin
    rdata_d = (bus_rd & permit & cfg_hit) ? cfg_word : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= blocked;
    end
  end

  assign bus_permit  = permit;
  assign conv_clk_en = ~cfg.halt;
  assign analog_pd   = cfg.halt;
  assign seq_abort   = cfg.halt;
  assign mode_enh    = cfg.enh;
endmodule

// File: rtl/adc_cfg_ctrl_chk.sv
module adc_cfg_ctrl_chk (
  input logic        clk,
  input logic        rst_sn,
  input logic        blk,
  input logic        bus_wr,
  input logic [15:0] cfg_word,
  input logic [15:0] bus_rdata,
  input logic        bus_err,
  input logic        frz_req,
  input logic        seq_hold,
  input logic        conv_ready,
  input logic        conv_clk_en,
  input logic        analog_pd
);
  // R2
  halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cfg_word[15] |-> (!conv_clk_en && analog_pd));
  // R3
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    conv_ready |-> !cfg_word[15]);
  // R5
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg_word[9] |=> $stable(cfg_word[8]));
  // R6
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !frz_req |=> !seq_hold);
  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !cfg_word[14] |=> !seq_hold);
  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    blk |=> bus_err);
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !blk |=> !bus_err);
  // R10
  blocked_wr_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (blk && bus_wr) |=> $stable(cfg_word));
  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rdata & 16'h3C7F) == 16'h0000);
endmodule

bind adc_cfg_ctrl adc_cfg_ctrl_chk u_chk (
  .clk(clk), .rst_sn(rst_s), .blk(blocked), .bus_wr(bus_wr),
  .cfg_word(cfg_word), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .frz_req(frz_req), .seq_hold(seq_hold), .conv_ready(conv_ready),
  .conv_clk_en(conv_clk_en), .analog_pd(analog_pd)
);

// File: tb/tb_adc_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_adc_cfg_ctrl;
  localparam int AW  = 4;
  localparam int REC = 8;

  logic          clk, rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr, bus_rd, bus_user;
  logic [15:0]   bus_wdata, bus_rdata;
  logic          bus_permit, bus_err, frz_req, conv_busy;
  logic          conv_clk_en, analog_pd, seq_abort, seq_hold, mode_enh, conv_ready;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic permit_s;

  adc_cfg_ctrl #(.ADDR_W(AW), .REC_CYC(REC)) dut (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic usr,
                     input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_user = usr; bus_addr = a; bus_wdata = d;
    #1 permit_s = bus_permit;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_user = 0;
  endtask

  task automatic rdcfg(output logic [15:0] v);
    bus(0, 1, 0, '0, 16'h0);
    v = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, cur;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_user = 0; bus_addr = '0;
    bus_wdata = '0; frz_req = 0; conv_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 clk_en", conv_clk_en, 1); chk("R1 pd", analog_pd, 0);
    chk("R1 abort", seq_abort, 0);    chk("R1 hold", seq_hold, 0);
    chk("R1 ready", conv_ready, 1);   chk("R1 mode", mode_enh, 0);
    chk("R1 err", bus_err, 0);
    rdcfg(v); chk("R1 word", v, 16'h0080);

    // R4 / R11 single-bit write sweep (unlock starts 0, so mode stays 0)
    for (int b = 0; b < 16; b++) begin
      bus(1, 0, 0, '0, 16'h0000);
      bus(1, 0, 0, '0, 16'(1 << b));
      rdcfg(v);
      chk($sformatf("R4 R11 bit%0d", b), v, 16'(1 << b) & 16'hC280);
    end
    bus(1, 0, 0, '0, 16'hFFFF); rdcfg(v);
    chk("R11 all ones", v, 16'hC280);

    // R2 halt
    bus(1, 0, 0, '0, 16'h8000);
    chk("R2 clk_en", conv_clk_en, 0); chk("R2 pd", analog_pd, 1);
    chk("R2 abort", seq_abort, 1);    chk("R3 ready while halted", conv_ready, 0);
    // R3 recovery count
    bus(1, 0, 0, '0, 16'h0000);
    chk("R2 released", conv_clk_en, 1);
    for (int i = 1; i <= REC; i++) begin
      @(negedge clk);
      chk($sformatf("R3 ready at %0d", i), conv_ready, (i == REC) ? 1 : 0);
    end
    // R3 restart
    bus(1, 0, 0, '0, 16'h8000);
    bus(1, 0, 0, '0, 16'h0000);
    repeat (3) @(negedge clk);
    bus(1, 0, 0, '0, 16'h8000);
    bus(1, 0, 0, '0, 16'h0000);
    for (int i = 1; i <= REC; i++) begin
      @(negedge clk);
      chk($sformatf("R3 restart at %0d", i), conv_ready, (i == REC) ? 1 : 0);
    end

    // R5 mode/unlock sequence: {data, expected mode}
    bus(1, 0, 0, '0, 16'h0100); chk("R5 locked", mode_enh, 0);
    bus(1, 0, 0, '0, 16'h0300); chk("R5 same access", mode_enh, 0);
    bus(1, 0, 0, '0, 16'h0300); chk("R5 unlocked set", mode_enh, 1);
    bus(1, 0, 0, '0, 16'h0100); chk("R5 lock keeps", mode_enh, 1);
    bus(1, 0, 0, '0, 16'h0000); chk("R5 locked hold", mode_enh, 1);
    bus(1, 0, 0, '0, 16'h0200); chk("R5 unlock only", mode_enh, 1);
    bus(1, 0, 0, '0, 16'h0000); chk("R5 unlocked clear", mode_enh, 0);

    // R6 freeze handshake
    bus(1, 0, 0, '0, 16'h4000);
    @(negedge clk); frz_req = 1; conv_busy = 1;
    repeat (3) begin @(negedge clk); chk("R6 wait busy", seq_hold, 0); end
    conv_busy = 0;
    @(negedge clk); chk("R6 ack", seq_hold, 1);
    conv_busy = 1;
    @(negedge clk); chk("R6 held", seq_hold, 1);
    conv_busy = 0; frz_req = 0;
    @(negedge clk); chk("R6 release", seq_hold, 0);
    // R7 ignored when disabled
    bus(1, 0, 0, '0, 16'h0000);
    frz_req = 1;
    repeat (3) begin @(negedge clk); chk("R7 ignored", seq_hold, 0); end
    frz_req = 0;

    // R8 R9 R10 privilege sweep
    for (int p = 0; p < 2; p++) begin
      cur = p ? 16'h0080 : 16'h0000;
      bus(1, 0, 0, '0, cur);
      for (int a = 0; a < (1 << AW); a++)
        for (int u = 0; u < 2; u++)
          for (int op = 0; op < 2; op++) begin
            logic prot, err;
            prot = (p == 1) || (a < 3);
            err  = (u == 1) && prot;
            bus(op == 1, op == 0, u[0], AW'(a),
                (a == 0 && u == 0) ? cur : 16'hFFFF);
            chk($sformatf("R8 R9 permit p%0d a%0d u%0d", p, a, u), permit_s, !err);
            chk($sformatf("R9 err p%0d a%0d u%0d", p, a, u), bus_err, err);
            if (op == 0)
              chk($sformatf("R10 R11 rdata a%0d u%0d", a, u), bus_rdata,
                  (a == 0 && !err) ? cur : 16'h0);
          end
      rdcfg(v); chk("R10 word unchanged", v, cur);
      @(negedge clk); chk("R9 pulse ends", bus_err, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule